// File: doc/BRIEF.md
# USB Device Frame-Sync Interrupt Controller

This block gathers the interrupt events of a USB device controller into one active-low interrupt pin. Event strobes come from the serial engine: start-of-frame (SOF), per-endpoint transfer done, bus reset, resume and end-of-transfer. Each strobe sets a sticky status bit. A per-source enable mask selects which pending bits can reach the pin, and a single global enable gates the pin as a whole. Firmware reads the status vector with a read pulse, and that pulse clears it.

A frame watchdog runs on a 1 ms timebase derived from the clock frequency parameter. Every real SOF restarts it. If a frame period passes without an SOF, the watchdog raises a pseudo-SOF event, and it raises another one every further millisecond. Firmware can therefore stay aligned with the host frame even when SOF tokens are lost. Consecutive missed frames are counted. When the count reaches the limit, the block enters a suspended state and raises a suspend event. A resume or a real SOF leaves that state.

Top module: `usb_frame_irq_ctrl`

## Requirements
- R1: After reset, every status bit is 0, the enable mask is 0, the global enable is 0, `irq_n` is 1 and `suspended` is 0.
- R2: A strobe held high in a cycle sets its status bit at that clock edge, whatever the mask holds. The bit positions are: 0 bus reset, 1 suspend, 2 resume, 3 end-of-transfer, 4 SOF, 5 pseudo-SOF, and 6+k for endpoint k.
- R3: `stat_rd` clears every status bit at the edge where it is sampled, except the bits whose event occurs in that same cycle, which stay set.
- R4: `irq_n` is 0 exactly when the global enable is 1 and at least one status bit is set whose mask bit is also set. Otherwise `irq_n` is 1.
- R5: `cfg_we` loads `cfg_mask` and `cfg_gie` at the edge. If enabled sources are already pending when the global enable goes from 0 to 1, `irq_n` falls right after that edge.
- R6: If no SOF arrives, the pseudo-SOF bit is set TICKS edges after the last SOF (or after reset is released), and again every TICKS edges after that. TICKS is CLK_HZ/1000.
- R7: A real SOF restarts the frame timer, so SOFs that arrive less than TICKS edges apart never produce a pseudo-SOF.
- R8: At the edge of the MISS_LIMIT-th consecutive pseudo-SOF, `suspended` rises and the suspend status bit is set in the same edge.
- R9: A real SOF or a bus reset clears the missed-frame count. After a bus reset, MISS_LIMIT further misses are needed before suspend.
- R10: `suspended` clears at the edge where a resume or a real SOF is sampled. A clear in the same cycle wins over a new suspend.
- R11: With only the SOF and pseudo-SOF bits enabled, endpoint events latch their status but leave `irq_n` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sof_stb | input | 1 | Real start-of-frame seen |
| ep_done | input | N_EP | Per-endpoint transfer-done strobes |
| bus_rst_stb | input | 1 | Bus reset seen |
| resume_stb | input | 1 | Resume signalling seen |
| eot_stb | input | 1 | End-of-transfer strobe |
| cfg_we | input | 1 | Load the mask and the global enable |
| cfg_mask | input | 6+N_EP | Per-source enable bits |
| cfg_gie | input | 1 | Global interrupt enable |
| stat_rd | input | 1 | Status read; clears the status |
| stat_q | output | 6+N_EP | Latched status vector |
| suspended | output | 1 | Suspend state |
| irq_n | output | 1 | Interrupt pin, active low |

## Verification
The bench sets CLK_HZ to 20000, which makes one millisecond equal to 20 clock cycles. It keeps MISS_LIMIT at 3 and N_EP at 4. With these values, a pseudo-SOF, a full three-frame march into suspend and a bus reset in the middle of a miss run all fit into a few dozen cycles. Random phases alternate between dense SOF traffic and long silences, so both the timer restart and the watchdog expiry occur many times during the run.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int SRC_BRST = 0;
  localparam int SRC_SUSP = 1;
  localparam int SRC_RESM = 2;
  localparam int SRC_EOT  = 3;
  localparam int SRC_SOF  = 4;
  localparam int SRC_PSOF = 5;
  localparam int SRC_EP0  = 6;

  // clock cycles in one millisecond, never below 2
  function automatic int ms_ticks(input int clk_hz);
    int t;
    t = clk_hz / 1000;
    return (t < 2) ? 2 : t;
  endfunction

  function automatic int bits_for(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/frame_watchdog.sv
module frame_watchdog
  import usb_irq_pkg::*;
#(
  parameter int CLK_HZ     = 48_000_000,
  parameter int MISS_LIMIT = 3,
  localparam int TICKS     = ms_ticks(CLK_HZ),
  localparam int TW        = bits_for(TICKS),
  localparam int MW        = bits_for(MISS_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_stb,
  input  logic          bus_rst_stb,
  input  logic          resume_stb,
  output logic          psof_evt,
  output logic          susp_evt,
  output logic          suspended,
  output logic [MW-1:0] miss_cnt
);
  logic [TW-1:0] age_q;
  logic          expire;

  assign expire   = (age_q == TW'(TICKS - 1)) && !sof_stb;
  assign psof_evt = expire;
  assign susp_evt = expire && !bus_rst_stb && (miss_cnt == MW'(MISS_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= '0;
    else if (sof_stb || expire) age_q <= '0;
    else                      age_q <= age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          miss_cnt <= '0;
    else if (sof_stb || bus_rst_stb)     miss_cnt <= '0;
    else if (expire && miss_cnt != MW'(MISS_LIMIT)) miss_cnt <= miss_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      suspended <= 1'b0;
    else if (resume_stb || sof_stb)  suspended <= 1'b0;
    else if (susp_evt)               suspended <= 1'b1;
  end
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr,
  output logic [NSRC-1:0] stat
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat[i] <= 1'b0;
      else if (evt[i]) stat[i] <= 1'b1;
      else if (clr)    stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cfg_gate.sv
module irq_cfg_gate #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [NSRC-1:0] cfg_mask,
  input  logic            cfg_gie,
  input  logic [NSRC-1:0] stat,
  output logic [NSRC-1:0] mask_q,
  output logic            gie_q,
  output logic            pend,
  output logic            irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else if (cfg_we) begin
      mask_q <= cfg_mask;
      gie_q  <= cfg_gie;
    end
  end

  assign pend  = |(stat & mask_q);
  assign irq_n = !(pend && gie_q);
endmodule

// File: rtl/usb_frame_irq_ctrl.sv
module usb_frame_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int CLK_HZ     = 48_000_000,
  parameter int MISS_LIMIT = 3,
  parameter int N_EP       = 15,
  localparam int NSRC      = SRC_EP0 + N_EP,
  localparam int MW        = bits_for(MISS_LIMIT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof_stb,
  input  logic [N_EP-1:0] ep_done,
  input  logic            bus_rst_stb,
  input  logic            resume_stb,
  input  logic            eot_stb,
  input  logic            cfg_we,
  input  logic [NSRC-1:0] cfg_mask,
  input  logic            cfg_gie,
  input  logic            stat_rd,
  output logic [NSRC-1:0] stat_q,
  output logic            suspended,
  output logic            irq_n
);
  logic            psof_evt;
  logic            susp_evt;
  logic [MW-1:0]   miss_cnt;
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] mask_q;
  logic            gie_q;
  logic            pend;

  frame_watchdog #(.CLK_HZ(CLK_HZ), .MISS_LIMIT(MISS_LIMIT)) u_wdog (
    .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .bus_rst_stb(bus_rst_stb),
    .resume_stb(resume_stb), .psof_evt(psof_evt), .susp_evt(susp_evt),
    .suspended(suspended), .miss_cnt(miss_cnt)
  );

  always_comb begin
    evt_vec = '0;
    evt_vec[SRC_BRST] = bus_rst_stb;
    evt_vec[SRC_SUSP] = susp_evt;
    evt_vec[SRC_RESM] = resume_stb;
    evt_vec[SRC_EOT]  = eot_stb;
    evt_vec[SRC_SOF]  = sof_stb;
    evt_vec[SRC_PSOF] = psof_evt;
    evt_vec[SRC_EP0 +: N_EP] = ep_done;
  end

  irq_latch_bank #(.NSRC(NSRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr(stat_rd), .stat(stat_q)
  );

  irq_cfg_gate #(.NSRC(NSRC)) u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mask(cfg_mask),
    .cfg_gie(cfg_gie), .stat(stat_q), .mask_q(mask_q), .gie_q(gie_q),
    .pend(pend), .irq_n(irq_n)
  );
endmodule

// File: rtl/usb_irq_chk.sv
module usb_irq_chk #(
  parameter int NSRC = 10,
  parameter int MW   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sof_stb,
  input logic            resume_stb,
  input logic            bus_rst_stb,
  input logic            stat_rd,
  input logic            cfg_we,
  input logic            cfg_gie,
  input logic [NSRC-1:0] evt_vec,
  input logic [NSRC-1:0] stat_q,
  input logic [NSRC-1:0] mask_q,
  input logic            gie_q,
  input logic            irq_n,
  input logic            psof_evt,
  input logic            suspended,
  input logic [MW-1:0]   miss_cnt
);
  // R2
  sof_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_stb |=> stat_q[4]);
  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && evt_vec == '0) |=> stat_q == '0);
  // R4
  pin_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> gie_q);
  // R4
  pin_follows_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_q && (stat_q & mask_q) != '0) |-> !irq_n);
  // R5
  gie_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> gie_q == $past(cfg_gie));
  // R7
  no_psof_on_sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psof_evt |-> !sof_stb);
  // R8
  suspend_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> stat_q[1]);
  // R9
  miss_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst_stb || sof_stb) |=> miss_cnt == '0);
  // R10
  suspend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_stb || sof_stb) |=> !suspended);
endmodule

bind usb_frame_irq_ctrl usb_irq_chk #(.NSRC(NSRC), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .resume_stb(resume_stb),
  .bus_rst_stb(bus_rst_stb), .stat_rd(stat_rd), .cfg_we(cfg_we),
  .cfg_gie(cfg_gie), .evt_vec(evt_vec), .stat_q(stat_q), .mask_q(mask_q),
  .gie_q(gie_q), .irq_n(irq_n), .psof_evt(psof_evt), .suspended(suspended),
  .miss_cnt(miss_cnt)
);

// File: tb/sim_usb_frame_irq_ctrl.sv
module sim_usb_frame_irq_ctrl;
  localparam int CLK_HZ = 20000;
  localparam int LIMIT  = 3;
  localparam int N_EP   = 4;
  localparam int NSRC   = 6 + N_EP;
  localparam int T      = CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic d_sof = 0, d_br = 0, d_rs = 0, d_eot = 0, d_we = 0, d_gie = 0, d_rd = 0;
  logic [N_EP-1:0] d_ep = '0;
  logic [NSRC-1:0] d_mask = '0;
  logic [NSRC-1:0] stat_q;
  logic suspended, irq_n;

  int errors = 0, checks = 0;
  bit done = 0;

  int m_age, m_miss;
  bit m_susp, m_gie;
  logic [NSRC-1:0] m_stat, m_mask;

  always #2.5 clk = ~clk;

  usb_frame_irq_ctrl #(.CLK_HZ(CLK_HZ), .MISS_LIMIT(LIMIT), .N_EP(N_EP)) u0 (
    .clk(clk), .rst_n(rst_n), .sof_stb(d_sof), .ep_done(d_ep),
    .bus_rst_stb(d_br), .resume_stb(d_rs), .eot_stb(d_eot), .cfg_we(d_we),
    .cfg_mask(d_mask), .cfg_gie(d_gie), .stat_rd(d_rd), .stat_q(stat_q),
    .suspended(suspended), .irq_n(irq_n)
  );

  function automatic bit want_irq_n(logic [NSRC-1:0] s, logic [NSRC-1:0] m, bit g);
    int hits = 0;
    for (int i = 0; i < NSRC; i++) if (s[i] && m[i]) hits++;
    return !(g && hits > 0);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_age = 0; m_miss = 0; m_susp = 0; m_gie = 0; m_stat = '0; m_mask = '0;
  endtask

  // one clock: advance reference, then compare outputs
  task automatic cyc();
    bit fire, sev;
    logic [NSRC-1:0] ev;
    @(posedge clk);
    fire = !d_sof && (m_age + 1 == T);
    sev  = fire && !d_br && (m_miss + 1 == LIMIT);
    ev = '0;
    ev[0] = d_br; ev[1] = sev; ev[2] = d_rs; ev[3] = d_eot;
    ev[4] = d_sof; ev[5] = fire;
    for (int k = 0; k < N_EP; k++) ev[6 + k] = d_ep[k];
    m_stat = (d_rd ? '0 : m_stat) | ev;
    m_age  = (d_sof || fire) ? 0 : m_age + 1;
    if (d_sof || d_br) m_miss = 0;
    else if (fire && m_miss < LIMIT) m_miss++;
    if (d_rs || d_sof) m_susp = 0;
    else if (sev) m_susp = 1;
    if (d_we) begin m_mask = d_mask; m_gie = d_gie; end
    #1;
    d_sof = 0; d_br = 0; d_rs = 0; d_eot = 0; d_we = 0; d_rd = 0; d_ep = '0;
    chk("R2 stat", 32'(stat_q), 32'(m_stat));
    chk("R4 irq_n", 32'(irq_n), 32'(want_irq_n(m_stat, m_mask, m_gie)));
    chk("R8 suspended", 32'(suspended), 32'(m_susp));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    model_reset();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1 reset state
    chk("R1 stat", 32'(stat_q), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
    chk("R1 suspended", 32'(suspended), 0);

    // R6 first pseudo-SOF T edges after reset
    idle(T - 1);
    chk("R6 early", 32'(stat_q[5]), 0);
    idle(1);
    chk("R6 psof", 32'(stat_q[5]), 1);

    // R7 SOF restarts timer
    d_rd = 1; cyc();
    for (int r = 0; r < 4; r++) begin
      d_sof = 1; cyc();
      idle(T - 3);
    end
    chk("R7 no psof", 32'(stat_q[5]), 0);

    // R8 march to suspend
    d_sof = 1; cyc();
    idle(3 * T - 1);
    chk("R8 not yet", 32'(suspended), 0);
    idle(1);
    chk("R8 suspended", 32'(suspended), 1);
    chk("R8 susp bit", 32'(stat_q[1]), 1);

    // R10 resume exits suspend
    d_rs = 1; cyc();
    chk("R10 resume", 32'(suspended), 0);

    // R9 bus reset restarts the miss count
    d_sof = 1; cyc();
    idle(2 * T);
    d_br = 1; cyc();
    idle(T);
    chk("R9 no suspend", 32'(suspended), 0);
    idle(2 * T);
    chk("R9 suspend later", 32'(suspended), 1);
    d_sof = 1; cyc();
    chk("R10 sof exit", 32'(suspended), 0);

    // R11 isochronous style: only SOF and pseudo-SOF enabled
    d_we = 1; d_mask = '0; d_mask[4] = 1; d_mask[5] = 1; d_gie = 1; cyc();
    d_rd = 1; cyc();
    d_ep = 4'b1011; cyc();
    chk("R11 ep latched", 32'(stat_q[9:6]), 32'hB);
    chk("R11 pin idle", 32'(irq_n), 1);
    d_sof = 1; cyc();
    chk("R11 sof pin", 32'(irq_n), 0);

    // R5 late global enable
    d_we = 1; d_mask = '1; d_gie = 0; cyc();
    d_rd = 1; cyc();
    d_eot = 1; cyc();
    chk("R5 gated", 32'(irq_n), 1);
    d_we = 1; d_mask = '1; d_gie = 1; cyc();
    chk("R5 opens", 32'(irq_n), 0);

    // R3 read with a same-cycle event
    d_rd = 1; d_eot = 1; cyc();
    chk("R3 kept", 32'(stat_q), 32'h8);
    d_rd = 1; cyc();
    chk("R3 cleared", 32'(stat_q), 0);

    // random phases: busy frames and silent gaps
    for (int i = 0; i < 3000; i++) begin
      bit busy;
      busy = ((i / 150) % 2) == 0;
      d_sof = busy && ($urandom % 12 == 0);
      d_ep  = (($urandom % 6) == 0) ? N_EP'($urandom) : '0;
      d_br  = ($urandom % 40) == 0;
      d_rs  = ($urandom % 50) == 0;
      d_eot = ($urandom % 16) == 0;
      d_rd  = ($urandom % 8) == 0;
      d_we  = ($urandom % 25) == 0;
      d_mask = NSRC'($urandom);
      d_gie = ($urandom % 4) != 0;
      cyc();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule